// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a fixed run of bytes from any source address into the sprite attribute table. The copy starts with a one-cycle trigger that carries a source base. It moves the bytes one at a time over a dedicated memory-master port that has separate read and write channels. Each byte uses one service slot: a read request in the first cycle of the slot, then a write of the returned byte in the second. Slots repeat at a fixed pace.

While the engine is busy it also sits between the CPU and the system bus. In that time only the high-RAM window passes through. Every other CPU read returns all ones, and every other CPU write is dropped. When the last byte has been written, normal bus access comes back and the engine gives a single-cycle completion pulse.

Top module: `sprite_copy_dma`

## Requirements
- R1: After reset the engine is idle. busy_o and done_o are low, and neither rd_en_o nor wr_en_o is asserted.
- R2: A trigger whose base is above 0xF100 is ignored and no transfer starts. A base of exactly 0xF100 is accepted.
- R3: In the cycle after an accepted trigger, rd_en_o is high with rd_addr_o equal to the base. In the next cycle, wr_en_o is high with wr_addr_o at 0xFE00 and wr_data_o equal to the byte returned on rd_data_i (one cycle of read latency).
- R4: Slots repeat every 4 cycles: read in slot cycle 0, write in slot cycle 1, and nothing in cycles 2 and 3. Source and destination each advance by one per byte.
- R5: Exactly 160 bytes are written per transfer. busy_o is high from the cycle after the trigger until the last write. In the cycle after the last write, busy_o is low and done_o is high for exactly one cycle.
- R6: While busy_o is high, a CPU access to an address below 0xFF80, or to 0xFFFF, is not forwarded to the system bus. A read of such an address returns 0xFF in the following cycle, and a write to it is discarded.
- R7: While busy_o is high, CPU accesses to 0xFF80 through 0xFFFE are forwarded unchanged. Read data comes back from the system bus one cycle later.
- R8: While busy_o is low, every CPU access is forwarded unchanged and its read data is returned from the system bus.
- R9: An accepted trigger while busy restarts the copy from the new base, with destination 0xFE00 and a full count of 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle start request |
| trig_base_i | input | 16 | Source base address for the copy |
| rd_en_o | output | 1 | Copy-port read request |
| rd_addr_o | output | 16 | Copy-port read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | Copy-port write request |
| wr_addr_o | output | 16 | Copy-port write address |
| wr_data_o | output | 8 | Copy-port write data |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, one cycle after request |
| sys_req_o | output | 1 | Forwarded system-bus request |
| sys_we_o | output | 1 | Forwarded write flag |
| sys_addr_o | output | 16 | Forwarded address |
| sys_wdata_o | output | 8 | Forwarded write data |
| sys_rdata_i | input | 8 | System-bus read data, one cycle after request |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 160 bytes, a pace of 4 cycles, the 0xF100 acceptance limit and the 0xFF80 to 0xFFFE high-RAM window. Under these values the full slot cadence is reachable, and so is the exact last-byte and done-pulse timing at byte 160. The default window bounds let the directed accesses hit the edges at 0xFF7F, 0xFF80, 0xFFFE and 0xFFFF. Bases on both sides of 0xF100 are exercised, and random restarts land in every slot phase.

// File: rtl/sprite_copy_pkg.sv
package sprite_copy_pkg;

  // Classification of one CPU bus cycle by the access gate.
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_PASS    = 2'd1,
    ACC_DROP_WR = 2'd2,
    ACC_DROP_RD = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/sprite_copy_seq.sv
module sprite_copy_seq #(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter int              NBYTES     = 160,
  parameter int              PACE       = 4,
  parameter logic [ADDR_W-1:0] DEST_BASE  = 16'hFE00,
  parameter logic [ADDR_W-1:0] BASE_LIMIT = 16'hF100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] trig_base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam int PH_W  = (PACE > 2) ? $clog2(PACE) : 1;
  localparam logic [PH_W-1:0]  PH_RD   = '0;
  localparam logic [PH_W-1:0]  PH_WR   = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PACE - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              start;
  logic              step_en;

  assign start   = trig_i && (trig_base_i <= BASE_LIMIT);
  assign step_en = start || busy_q || done_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    ph_d   = ph_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      ph_d   = PH_RD;
      src_d  = trig_base_i;
      dst_d  = DEST_BASE;
      cnt_d  = CNT_FULL;
    end else if (busy_q) begin
      ph_d = (ph_q == PH_LAST) ? PH_RD : ph_q + PH_W'(1);
      if (ph_q == PH_WR) begin
        src_d = src_q + ADDR_W'(1);
        dst_d = dst_q + ADDR_W'(1);
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_ONE) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      ph_q   <= ph_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rd_en_o   = busy_q && (ph_q == PH_RD);
  assign rd_addr_o = src_q;
  assign wr_en_o   = busy_q && (ph_q == PH_WR);
  assign wr_addr_o = dst_q;
  assign wr_data_o = rd_data_i;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && !start) |=> wr_en_o);

  // R4
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !start) |=> (rd_en_o == (PACE == 2)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !rd_en_o && !wr_en_o));

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && (trig_base_i > BASE_LIMIT) && !busy_o) |=> !busy_o);

  // R4
  port_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o));

endmodule

// File: rtl/sprite_copy_gate.sv
module sprite_copy_gate
  import sprite_copy_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HRAM_LO = 16'hFF80,
  parameter logic [ADDR_W-1:0] HRAM_HI = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              sys_req_o,
  output logic              sys_we_o,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic [DATA_W-1:0] sys_wdata_o,
  input  logic [DATA_W-1:0] sys_rdata_i
);

  localparam logic [DATA_W-1:0] FILL = '1;

  acc_kind_e kind;
  logic      in_hram;
  logic      blk_q, blk_d;

  assign in_hram = (cpu_addr_i >= HRAM_LO) && (cpu_addr_i <= HRAM_HI);

  always_comb begin
    if (!cpu_req_i)            kind = ACC_IDLE;
    else if (!busy_i || in_hram) kind = ACC_PASS;
    else if (cpu_we_i)         kind = ACC_DROP_WR;
    else                       kind = ACC_DROP_RD;
  end

  assign blk_d = (kind == ACC_DROP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= blk_d;
  end

  assign sys_req_o   = (kind == ACC_PASS);
  assign sys_we_o    = cpu_we_i;
  assign sys_addr_o  = cpu_addr_i;
  assign sys_wdata_o = cpu_wdata_i;
  assign cpu_rdata_o = blk_q ? FILL : sys_rdata_i;

  // R6
  blocked_read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && !cpu_we_i && busy_i && !in_hram) |=> (cpu_rdata_o == FILL));

  // R7
  hram_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && in_hram) |-> sys_req_o);

  // R8
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && !cpu_we_i && !busy_i) |=> (cpu_rdata_o == sys_rdata_i));

endmodule

// File: rtl/sprite_copy_dma.sv
module sprite_copy_dma #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                NBYTES     = 160,
  parameter int                PACE       = 4,
  parameter logic [ADDR_W-1:0] DEST_BASE  = 16'hFE00,
  parameter logic [ADDR_W-1:0] BASE_LIMIT = 16'hF100,
  parameter logic [ADDR_W-1:0] HRAM_LO    = 16'hFF80,
  parameter logic [ADDR_W-1:0] HRAM_HI    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] trig_base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              sys_req_o,
  output logic              sys_we_o,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic [DATA_W-1:0] sys_wdata_o,
  input  logic [DATA_W-1:0] sys_rdata_i,
  output logic              busy_o,
  output logic              done_o
);

  logic rst_meta_q, rst_sync_q;
  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sprite_copy_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES), .PACE(PACE),
    .DEST_BASE(DEST_BASE), .BASE_LIMIT(BASE_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .trig_i(trig_i), .trig_base_i(trig_base_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .busy_o(busy), .done_o(done_o)
  );

  sprite_copy_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HRAM_LO(HRAM_LO), .HRAM_HI(HRAM_HI)
  ) u_gate (
    .clk(clk), .rst_n(rst_sync_q), .busy_i(busy),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .sys_req_o(sys_req_o), .sys_we_o(sys_we_o), .sys_addr_o(sys_addr_o),
    .sys_wdata_o(sys_wdata_o), .sys_rdata_i(sys_rdata_i)
  );

  assign busy_o = busy;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_q |=> (!busy_o && !done_o));

endmodule

// File: tb/sprite_copy_dma_tb_top.sv
module sprite_copy_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [15:0] trig_base;
  logic        rd_en, wr_en;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        sys_req, sys_we;
  logic [15:0] sys_addr;
  logic [7:0]  sys_wdata, sys_rdata;
  logic        busy, done;

  int vectors = 0;
  int fails   = 0;
  bit wd_hit  = 1'b0;

  always #10 clk = ~clk;

  sprite_copy_dma dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_base_i(trig_base),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .sys_req_o(sys_req), .sys_we_o(sys_we), .sys_addr_o(sys_addr),
    .sys_wdata_o(sys_wdata), .sys_rdata_i(sys_rdata),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] sys_byte(input logic [15:0] a);
    return (a[7:0] + a[15:8]) ^ 8'hA5;
  endfunction

  function automatic bit hram(input logic [15:0] a);
    return (a >= 16'hFF80) && (a <= 16'hFFFE);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory models with one cycle of latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= src_byte(rd_addr);
    if (sys_req && !sys_we) sys_rdata <= sys_byte(sys_addr);
  end

  // reference model of the copy sequence
  logic        m_act, m_done;
  logic [1:0]  m_ph;
  logic [15:0] m_src, m_dst;
  int          m_cnt, m_wseen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0; m_done <= 1'b0; m_ph <= 2'd0;
      m_src <= 16'h0; m_dst <= 16'h0; m_cnt <= 0; m_wseen <= 0;
    end else begin
      m_done <= 1'b0;
      if (trig && trig_base <= 16'hF100) begin
        m_act <= 1'b1; m_ph <= 2'd0; m_src <= trig_base;
        m_dst <= 16'hFE00; m_cnt <= 160; m_wseen <= 0;
      end else begin
        if (wr_en) m_wseen <= m_wseen + 1;
        if (m_act) begin
          m_ph <= m_ph + 2'd1;
          if (m_ph == 2'd1) begin
            m_src <= m_src + 16'd1;
            m_dst <= m_dst + 16'd1;
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
              m_act <= 1'b0;
              m_done <= 1'b1;
            end
          end
        end
      end
    end
  end

  bit mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en && !wd_hit) begin
      chk(busy === m_act, "R5 busy", busy, m_act);
      chk(done === m_done, "R5 done", done, m_done);
      chk(rd_en === (m_act && m_ph == 2'd0), "R3 rd_en", rd_en, m_act && m_ph == 2'd0);
      if (m_act && m_ph == 2'd0)
        chk(rd_addr === m_src, "R4 rd_addr", rd_addr, m_src);
      chk(wr_en === (m_act && m_ph == 2'd1), "R4 wr_en", wr_en, m_act && m_ph == 2'd1);
      if (m_act && m_ph == 2'd1) begin
        chk(wr_addr === m_dst, "R3 wr_addr", wr_addr, m_dst);
        chk(wr_data === src_byte(m_src), "R3 wr_data", wr_data, src_byte(m_src));
      end
      if (m_done)
        chk(m_wseen == 160, "R5 byte count", m_wseen, 160);
    end
  end

  // one cycle of stimulus with CPU gate checking
  bit          pend_rd = 1'b0;
  logic [7:0]  pend_exp;
  string       pend_tag;

  task automatic tick(input bit t, input logic [15:0] tb, input bit rq,
                      input bit we, input logic [15:0] a, input logic [7:0] wd);
    bit allow;
    string tag;
    @(negedge clk); #2;
    if (pend_rd) chk(cpu_rdata === pend_exp, pend_tag, cpu_rdata, pend_exp);
    trig = t; trig_base = tb;
    cpu_req = rq; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    allow = !m_act || hram(a);
    tag = !m_act ? "R8 forward" : (hram(a) ? "R7 forward" : "R6 block");
    chk(sys_req === (rq && allow), tag, sys_req, rq && allow);
    if (rq && allow)
      chk({sys_we, sys_addr, sys_wdata} === {we, a, wd}, tag, {sys_we, sys_addr, sys_wdata}, {we, a, wd});
    pend_rd  = rq && !we;
    pend_exp = allow ? sys_byte(a) : 8'hFF;
    pend_tag = !m_act ? "R8 rdata" : (hram(a) ? "R7 rdata" : "R6 rdata");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic rnd_cycle(input int retrig_odds);
    logic [15:0] a;
    bit t;
    logic [15:0] b;
    case ($urandom % 4)
      0: a = 16'hFF80 + 16'($urandom % 128);
      1: a = 16'hFF00 + 16'($urandom % 128);
      default: a = 16'($urandom);
    endcase
    t = (retrig_odds > 0) && (($urandom % retrig_odds) == 0);
    b = 16'($urandom % 16'hF101);
    tick(t, b, ($urandom % 2) == 1, ($urandom % 2) == 1, a, 8'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; trig = 1'b0; trig_base = 16'h0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 16'h0; cpu_wdata = 8'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk({busy, done, rd_en, wr_en} === 4'b0, "R1 reset outputs", {busy, done, rd_en, wr_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    mon_en = 1'b1;
    idle(2);
    chk({busy, done, rd_en, wr_en} === 4'b0, "R1 idle after reset", {busy, done, rd_en, wr_en}, 0);

    // R2: rejected bases
    tick(1'b1, 16'hF101, 1'b0, 1'b0, 16'h0, 8'h0);
    idle(3);
    chk(busy === 1'b0, "R2 base F101 ignored", busy, 0);
    tick(1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0, 8'h0);
    idle(3);
    chk(busy === 1'b0, "R2 base FFFF ignored", busy, 0);

    // R2/R3: limit base accepted, first read at base
    tick(1'b1, 16'hF100, 1'b0, 1'b0, 16'h0, 8'h0);
    tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    chk(rd_en && rd_addr === 16'hF100, "R2 base F100 accepted", rd_addr, 16'hF100);
    // R6/R7 window edges while busy
    tick(1'b0, 16'h0, 1'b1, 1'b0, 16'hFF7F, 8'h0);
    tick(1'b0, 16'h0, 1'b1, 1'b0, 16'hFF80, 8'h0);
    tick(1'b0, 16'h0, 1'b1, 1'b0, 16'hFFFE, 8'h0);
    tick(1'b0, 16'h0, 1'b1, 1'b0, 16'hFFFF, 8'h0);
    tick(1'b0, 16'h0, 1'b1, 1'b1, 16'hFFFF, 8'h12);
    tick(1'b0, 16'h0, 1'b1, 1'b1, 16'hC000, 8'h34);
    tick(1'b0, 16'h0, 1'b1, 1'b1, 16'hFF90, 8'h56);
    // R9: restart mid-transfer
    idle(37);
    tick(1'b1, 16'h1234, 1'b0, 1'b0, 16'h0, 8'h0);
    tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    chk(rd_en && rd_addr === 16'h1234, "R9 restart base", rd_addr, 16'h1234);
    tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    chk(wr_en && wr_addr === 16'hFE00, "R9 restart dest", wr_addr, 16'hFE00);
    while (busy) tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    chk(done === 1'b1, "R5 done after last write", done, 1);
    tick(1'b0, 16'h0, 1'b1, 1'b0, 16'h4000, 8'h0);
    tick(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    chk(done === 1'b0, "R5 done single cycle", done, 0);

    // base 0, then random transfers with random restarts and CPU traffic
    tick(1'b1, 16'h0000, 1'b0, 1'b0, 16'h0, 8'h0);
    for (int n = 0; n < 30; n++) begin
      for (int c = 0; c < 700; c++) rnd_cycle(((n % 3) == 0) ? 500 : 0);
      if (($urandom % 5) == 0)
        tick(1'b1, 16'hF101 + 16'($urandom % 16'h0EFF), 1'b0, 1'b0, 16'h0, 8'h0);
      else
        tick(1'b1, 16'($urandom % 16'hF101), 1'b0, 1'b0, 16'h0, 8'h0);
    end
    for (int c = 0; c < 700; c++) rnd_cycle(0);
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule